// File: doc/BRIEF.md
# Prioritized Two-Class Interrupt Controller

This block collects 64 interrupt sources and presents them to a processor as two request lines: a fast class and a normal class. A rising edge on any source sets a pending bit for that source. Software gives each source a 3-bit priority, and that value also picks the class. Values 0 and 1 select the fast class; values 2 to 7 select the normal class.

Within each class, the pending source that is enabled and has the numerically smallest priority wins. The block drives a registered request line and a registered winner number for each class. Software reads an entry address for each class, formed from a programmable base plus a per-source offset. Software acknowledges a request by writing ones to the pending word of that source's class.

All state sits on a plain 32-bit word bus with a byte address, a write strobe and one-cycle read latency.

Top module: `prio_intc`

## Requirements
- R1: After reset, all enables read 0, all pending bits read 0, every priority field reads 7 (so each priority word reads 0x77777777), the control and base words read 0, and both request outputs are low.
- R2: A rising edge on source n sets its pending bit. That bit appears at bit n mod 32 of the low word (n < 32) or the high word (n ≥ 32). Fast-class pending words are at 0x00 (low) and 0x04 (high). Normal-class pending words are at 0x08 (low) and 0x0C (high). A source appears only in the words of its own class.
- R3: Writing a 1 to a pending word clears that bit only if the source belongs to that word's class. Bits written as 0 are unchanged, and ones written to the other class's word have no effect.
- R4: If a rising edge and a clearing write hit the same source in the same cycle, the pending bit stays set.
- R5: The enable words at 0x18 (low) and 0x1C (high) read back what was written. A pending source affects the outputs only while its enable bit is 1. Clearing an enable removes the source from the outputs on the next clock.
- R6: Priority word w (address 0x30 + 4w, w = 0..7) holds sources 8w to 8w+7. Source k uses bits [4*(k mod 8)+2 : 4*(k mod 8)], and the fourth bit of each nibble reads 0. Priorities 0 and 1 route a source to the fast class; priorities 2 to 7 route it to the normal class.
- R7: In each class, the winner is the enabled pending source with the smallest priority value; ties go to the lowest source number. The winner number is driven on `fiq_id_o` / `irq_id_o`.
- R8: `fiq_o` and `irq_o` are registered. Each goes high one clock after an enabled pending source of its class exists, not in the cycle its pending bit is set.
- R9: The entry words at 0x10 (fast) and 0x14 (normal) read base + (winner + 1) × 4. They read the base alone when the class has no enabled pending source.
- R10: The control word at 0x20 and the base word at 0x24 read back what was written. Writing the control word has no effect on arbitration or outputs.
- R11: Reads return data one clock after the address is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source inputs, edge-detected |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| fiq_o | output | 1 | Fast-class request |
| fiq_id_o | output | 6 | Fast-class winning source number |
| irq_o | output | 1 | Normal-class request |
| irq_id_o | output | 6 | Normal-class winning source number |

## Verification
The block has no overrides to choose: the bench builds it with its fixed 64 sources. This reaches both pending halves, source numbers 0, 31, 32 and 63 at the word edges, and priority words at both ends of the map. The vector table covers every class boundary, from priority 0 up to priority 7. The directed part covers ties, the smallest-value rule across the two words, immediate masking, class-restricted clearing, and a rising edge that collides with a clearing write.

// File: rtl/prio_intc.sv
module prio_intc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] src_i,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        fiq_o,
  output logic [5:0]  fiq_id_o,
  output logic        irq_o,
  output logic [5:0]  irq_id_o
);

  logic [63:0] src_q, pend, en, fiq_cls, rise, clr, act;
  logic [2:0]  pri [64];
  logic [31:0] ctl, base;
  logic        f_hit, i_hit;
  logic [5:0]  f_id, i_id;
  logic [2:0]  f_best, i_best;
  logic [31:0] f_entry, i_entry, pri_rd, rd_nxt;
  logic        wr_pri;
  logic [2:0]  pri_sel;

  assign rise = src_i & ~src_q;
  assign act  = pend & en;

  always_comb
    for (int i = 0; i < 64; i++) fiq_cls[i] = (pri[i] < 3'd2);

  assign clr[31:0]  = (bus_we && bus_addr == 8'h00) ? (bus_wdata &  fiq_cls[31:0]) :
                      (bus_we && bus_addr == 8'h08) ? (bus_wdata & ~fiq_cls[31:0]) : 32'd0;
  assign clr[63:32] = (bus_we && bus_addr == 8'h04) ? (bus_wdata &  fiq_cls[63:32]) :
                      (bus_we && bus_addr == 8'h0C) ? (bus_wdata & ~fiq_cls[63:32]) : 32'd0;

  assign pri_sel = 3'(bus_addr[7:2] - 6'd12);
  assign wr_pri  = bus_we && (bus_addr >= 8'h30) && (bus_addr <= 8'h4C) && (bus_addr[1:0] == 2'b00);

  always_comb begin
    f_hit = 1'b0; f_id = '0; f_best = 3'd7;
    i_hit = 1'b0; i_id = '0; i_best = 3'd7;
    for (int i = 0; i < 64; i++) begin
      if (act[i] && fiq_cls[i] && (!f_hit || pri[i] < f_best)) begin
        f_hit = 1'b1; f_id = 6'(i); f_best = pri[i];
      end
      if (act[i] && !fiq_cls[i] && (!i_hit || pri[i] < i_best)) begin
        i_hit = 1'b1; i_id = 6'(i); i_best = pri[i];
      end
    end
  end

  assign f_entry = base + (f_hit ? ({24'd0, f_id, 2'b00} + 32'd4) : 32'd0);
  assign i_entry = base + (i_hit ? ({24'd0, i_id, 2'b00} + 32'd4) : 32'd0);

  always_comb begin
    pri_rd = '0;
    for (int j = 0; j < 8; j++) pri_rd[4*j +: 3] = pri[{pri_sel, 3'(j)}];
  end

  always_comb begin
    case (bus_addr)
      8'h00: rd_nxt = pend[31:0]  &  fiq_cls[31:0];
      8'h04: rd_nxt = pend[63:32] &  fiq_cls[63:32];
      8'h08: rd_nxt = pend[31:0]  & ~fiq_cls[31:0];
      8'h0C: rd_nxt = pend[63:32] & ~fiq_cls[63:32];
      8'h10: rd_nxt = f_entry;
      8'h14: rd_nxt = i_entry;
      8'h18: rd_nxt = en[31:0];
      8'h1C: rd_nxt = en[63:32];
      8'h20: rd_nxt = ctl;
      8'h24: rd_nxt = base;
      8'h30, 8'h34, 8'h38, 8'h3C,
      8'h40, 8'h44, 8'h48, 8'h4C: rd_nxt = pri_rd;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= '0;
      pend      <= '0;
      en        <= '0;
      ctl       <= '0;
      base      <= '0;
      for (int i = 0; i < 64; i++) pri[i] <= 3'd7;
      bus_rdata <= '0;
      fiq_o     <= 1'b0;
      fiq_id_o  <= '0;
      irq_o     <= 1'b0;
      irq_id_o  <= '0;
    end else begin
      src_q <= src_i;
      pend  <= (pend & ~clr) | rise;
      if (bus_we) begin
        case (bus_addr)
          8'h18: en[31:0]  <= bus_wdata;
          8'h1C: en[63:32] <= bus_wdata;
          8'h20: ctl       <= bus_wdata;
          8'h24: base      <= bus_wdata;
          default: ;
        endcase
      end
      if (wr_pri)
        for (int j = 0; j < 8; j++) pri[{pri_sel, 3'(j)}] <= bus_wdata[4*j +: 3];
      bus_rdata <= rd_nxt;
      fiq_o     <= f_hit;
      fiq_id_o  <= f_id;
      irq_o     <= i_hit;
      irq_id_o  <= i_id;
    end
  end

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] src_i,
  input logic [63:0] src_q,
  input logic [63:0] pend,
  input logic [63:0] en,
  input logic [63:0] fiq_cls,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic        fiq_o,
  input logic [5:0]  fiq_id_o,
  input logic        irq_o,
  input logic [5:0]  irq_id_o
);

  logic [63:0] edge_now;
  assign edge_now = src_i & ~src_q;

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(edge_now)) == $past(edge_now)));

  assert_clear_normal_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h08) |=>
      ((pend[31:0] & $past(bus_wdata & ~fiq_cls[31:0] & ~edge_now[31:0])) == 32'd0));

  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|en));

  assert_class_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && irq_o) |-> (fiq_id_o != irq_id_o));

  assert_fiq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & en & fiq_cls)) |=> fiq_o);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & en & ~fiq_cls)) |=> irq_o);

endmodule

bind prio_intc prio_intc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .src_q(src_q), .pend(pend), .en(en),
  .fiq_cls(fiq_cls), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .fiq_o(fiq_o), .fiq_id_o(fiq_id_o), .irq_o(irq_o), .irq_id_o(irq_id_o)
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;
  logic [5:0]  fiq_id, irq_id;
  int          total = 0;
  int          errs = 0;
  logic [2:0]  pm [64];
  logic [31:0] rv;

  localparam logic [31:0] BASE = 32'h0000_1000;
  // {source, priority, expect fast class}
  localparam logic [9:0] VEC [8] = '{
    {6'd0,  3'd0, 1'b1}, {6'd31, 3'd1, 1'b1}, {6'd32, 3'd2, 1'b0}, {6'd63, 3'd7, 1'b0},
    {6'd17, 3'd5, 1'b0}, {6'd45, 3'd1, 1'b1}, {6'd8,  3'd3, 1'b0}, {6'd50, 3'd0, 1'b1}
  };

  always #10 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .fiq_o(fiq), .fiq_id_o(fiq_id),
    .irq_o(irq), .irq_id_o(irq_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(posedge clk); #1 d = rdata;
  endtask

  task automatic pulse(input logic [63:0] m);
    @(negedge clk); src = src | m;
    @(negedge clk); src = src & ~m;
  endtask

  function automatic logic [31:0] pack(input int r);
    logic [31:0] p = '0;
    for (int j = 0; j < 8; j++) p[4*j +: 3] = pm[r*8 + j];
    return p;
  endfunction

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  initial begin
    #4_000_000;
    errs++; total++;
    $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", total - errs, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) pm[i] = 3'd7;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 fast out", {31'd0, fiq}, 32'd0);
    chk("R1 normal out", {31'd0, irq}, 32'd0);
    rd(8'h18, rv); chk("R1 enable lo", rv, 32'd0);
    rd(8'h1C, rv); chk("R1 enable hi", rv, 32'd0);
    rd(8'h30, rv); chk("R1 prio word 0", rv, 32'h7777_7777);
    rd(8'h4C, rv); chk("R1 prio word 7", rv, 32'h7777_7777);
    rd(8'h08, rv); chk("R1 pending", rv, 32'd0);
    rd(8'h24, rv); chk("R1 base", rv, 32'd0);

    wr(8'h24, BASE);

    for (int v = 0; v < 8; v++) begin
      int s;
      logic [2:0] p;
      logic ef;
      logic [31:0] bm;
      logic [7:0] hi;
      s  = int'(VEC[v][9:4]);
      p  = VEC[v][3:1];
      ef = VEC[v][0];
      bm = 32'd1 << (s % 32);
      hi = (s >= 32) ? 8'h04 : 8'h00;
      pm[s] = p;
      wr(8'h30 + 8'(4 * (s / 8)), pack(s / 8));
      wr(8'h18 + hi, bm);
      pulse(64'd1 << s);
      chk("R8 no request yet", {30'd0, fiq, irq}, 32'd0);
      @(posedge clk); #1;
      chk("R6 fast line", {31'd0, fiq}, {31'd0, ef});
      chk("R6 normal line", {31'd0, irq}, {31'd0, ~ef});
      chk("R7 winner id", {26'd0, ef ? fiq_id : irq_id}, 32'(s));
      rd((ef ? 8'h00 : 8'h08) + hi, rv); chk("R2 own-class pending", rv, bm);
      rd((ef ? 8'h08 : 8'h00) + hi, rv); chk("R2 other-class pending", rv, 32'd0);
      rd(ef ? 8'h10 : 8'h14, rv); chk("R9 entry", rv, BASE + 32'((s + 1) * 4));
      rd(ef ? 8'h14 : 8'h10, rv); chk("R9 idle entry", rv, BASE);
      rd(8'h30 + 8'(4 * (s / 8)), rv); chk("R6 prio readback", rv, pack(s / 8));
      wr(8'h18, 32'd0); wr(8'h1C, 32'd0);
      wr(8'h00, '1); wr(8'h04, '1); wr(8'h08, '1); wr(8'h0C, '1);
      settle();
    end

    // R7 tie between sources 3 and 5 at priority 4
    pm[3] = 3'd4; pm[5] = 3'd4;
    wr(8'h30, pack(0));
    wr(8'h18, 32'h28);
    pulse(64'h28);
    @(posedge clk); #1;
    chk("R7 tie lowest number", {26'd0, irq_id}, 32'd3);

    // R7 smaller value wins across words
    pm[40] = 3'd2;
    wr(8'h44, pack(5));
    wr(8'h1C, 32'h100);
    pulse(64'd1 << 40);
    @(posedge clk); #1;
    chk("R7 smaller value wins", {26'd0, irq_id}, 32'd40);
    rd(8'h14, rv); chk("R9 entry src 40", rv, BASE + 32'd164);

    // R5 masking takes effect on the next clock
    wr(8'h1C, 32'd0);
    @(posedge clk); #1;
    chk("R5 masked winner dropped", {26'd0, irq_id}, 32'd3);
    wr(8'h18, 32'd0);
    @(posedge clk); #1;
    chk("R5 all masked", {31'd0, irq}, 32'd0);
    rd(8'h08, rv); chk("R5 pending kept while masked", rv, 32'h28);
    rd(8'h1C, rv); chk("R5 enable readback", rv, 32'd0);

    // R3 class-restricted clearing
    wr(8'h00, 32'h28);
    rd(8'h08, rv); chk("R3 other-class word ignored", rv, 32'h28);
    wr(8'h08, 32'h08);
    rd(8'h08, rv); chk("R3 zero bits unchanged", rv, 32'h20);

    // R4 edge and clear in the same cycle
    @(negedge clk); src[5] = 1'b1; addr = 8'h08; wdata = 32'h20; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(8'h08, rv); chk("R4 edge beats clear", rv, 32'h20);
    wr(8'h08, 32'h20);
    rd(8'h08, rv); chk("R4 held high clears", rv, 32'd0);
    @(negedge clk); src[5] = 1'b0;
    wr(8'h0C, '1);

    // R10 control and base
    wr(8'h20, 32'hA5);
    rd(8'h20, rv); chk("R10 control readback", rv, 32'hA5);
    rd(8'h24, rv); chk("R10 base readback", rv, BASE);
    chk("R10 control no effect", {30'd0, fiq, irq}, 32'd0);

    // R11 and R9 idle
    rd(8'h2C, rv); chk("R11 unmapped 0x2C", rv, 32'd0);
    rd(8'h50, rv); chk("R11 unmapped 0x50", rv, 32'd0);
    rd(8'h10, rv); chk("R9 nothing pending", rv, BASE);

    $display("%0d/%0d checks passed", total - errs, total);
    $finish;
  end
endmodule